// File: doc/BRIEF.md
# Framed Serial Packet Transmitter

This block turns a response descriptor into a byte stream for a serial transmitter. The descriptor is a message type, a length code and a 24-bit address. A caller pulses a start strobe while the block is idle, and the block then emits a fixed sequence. The sequence opens with a start delimiter, followed by the header fields and a variable-length payload. After the payload come a CRC byte and a closing delimiter. Every byte leaves through a valid/ready handshake, so a slow serializer simply stalls the sequence.

The block does not store the payload. It pulls each payload byte from a read path with a single-cycle request and takes the byte on the next cycle. Only one payload byte is held at a time. The CRC is built up one byte at a time as the covered bytes are accepted downstream, so no second pass over the frame is needed.

Top module: `frm_pkt_tx`

## Requirements
- R1: The first byte of every frame is the start delimiter 0x3C.
- R2: After the start delimiter the block emits the type byte, then the length byte, then the address as three bytes, most significant byte (bits 23:16) first.
- R3: The length byte carries the payload byte count minus one, so codes 0x00 to 0xFF give 1 to 256 payload bytes. The payload bytes follow the address in the order they were requested.
- R4: The byte after the last payload byte is a CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first with no reflection and no final XOR. It covers the type, length, address and payload bytes, and neither delimiter.
- R5: The last byte of every frame is the end delimiter 0xA5.
- R6: A byte counts as transferred only in a cycle where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value.
- R7: A start pulse is accepted only while busy is low, and the header inputs are captured on that edge. A start pulse while busy is high has no effect on the frame in progress and does not queue another frame.
- R8: busy rises in the cycle after an accepted start. It stays high until the clock edge on which the end delimiter is transferred, and it is low in the cycle after that edge. out_valid is never high while busy is low.
- R9: pl_req is a single-cycle pulse issued only while payload bytes are still owed. The requested byte must be on pl_data in the next cycle. No further request is issued until the byte held is transferred, and the number of requests per frame equals the payload count.
- R10: After reset, busy, out_valid and pl_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| hdr_type | input | 8 | Message type byte |
| hdr_len | input | 8 | Payload count minus one |
| hdr_addr | input | 24 | Address, sent high byte first |
| busy | output | 1 | Frame in progress |
| pl_req | output | 1 | Single-cycle request for the next payload byte |
| pl_data | input | 8 | Payload byte, valid the cycle after pl_req |
| out_data | output | 8 | Byte toward the serializer |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Serializer accepts the byte |

## Verification
The hardest conditions to reach from the ports involve a start pulse that lands mid-frame or exactly on the end-delimiter transfer. Such a pulse, arriving with a different header, must leave both the stream and busy untouched. To reach them, the bench raises start with a junk header at a chosen cycle while a frame is under backpressure. It also launches the next frame in the first idle cycle after the end delimiter. A 256-byte payload frame under a random ready pattern exercises the length wrap, where code 0xFF must end the payload after exactly 256 requests.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SOF,
        S_TYPE,
        S_LEN,
        S_ADDR,
        S_PAY,
        S_CRC,
        S_EOF
    } frm_state_e;

    localparam logic [7:0] FRM_SOF_BYTE = 8'h3C;
    localparam logic [7:0] FRM_EOF_BYTE = 8'hA5;

    // one byte through an MSB-first CRC-8 shift register
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc_in ^ din;
        for (int b = 0; b < 8; b++) begin
            if (c[7]) c = {c[6:0], 1'b0} ^ poly;
            else      c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/frm_crc8.sv
module frm_crc8 #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import frm_pkg::*;

    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = INIT;
        else if (en) crc_d = crc8_step(crc_q, din, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R4
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == INIT));

endmodule

// File: rtl/frm_fetch.sv
module frm_fetch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want,
    input  logic          take,
    input  logic [DW-1:0] pl_data,
    output logic          pl_req,
    output logic          hold_v,
    output logic [DW-1:0] hold_data
);
    typedef struct packed {
        logic          pend;
        logic          v;
        logic [DW-1:0] data;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        pl_req = want && !f_q.v && !f_q.pend;
        f_d.pend = pl_req;
        if (f_q.pend) begin
            f_d.v    = 1'b1;
            f_d.data = pl_data;
        end else if (take) begin
            f_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign hold_v    = f_q.v;
    assign hold_data = f_q.data;

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_req |=> !pl_req);
    // R9
    req_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_req |=> ##1 hold_v);
    // R6
    take_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_v);

endmodule

// File: rtl/frm_seq.sv
module frm_seq #(
    parameter int DW         = 8,
    parameter int ADDR_BYTES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DW-1:0]            hdr_type,
    input  logic [DW-1:0]            hdr_len,
    input  logic [DW*ADDR_BYTES-1:0] hdr_addr,
    input  logic                     out_ready,
    input  logic                     hold_v,
    input  logic [DW-1:0]            hold_data,
    input  logic [DW-1:0]            crc,
    output logic                     out_valid,
    output logic [DW-1:0]            out_data,
    output logic                     busy,
    output logic                     fetch_want,
    output logic                     pay_take,
    output logic                     crc_clr,
    output logic                     crc_en
);
    import frm_pkg::*;

    localparam int ADDR_W = DW * ADDR_BYTES;

    typedef struct packed {
        frm_state_e        st;
        logic [DW-1:0]     typ;
        logic [DW-1:0]     len;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic fire;
    logic [DW-1:0] addr_byte;

    always_comb begin
        addr_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (s_q.cnt == DW'(i)) addr_byte = s_q.addr[i*DW +: DW];
    end

    always_comb begin
        out_valid = 1'b1;
        out_data  = '0;
        case (s_q.st)
            S_IDLE: out_valid = 1'b0;
            S_SOF:  out_data  = FRM_SOF_BYTE;
            S_TYPE: out_data  = s_q.typ;
            S_LEN:  out_data  = s_q.len;
            S_ADDR: out_data  = addr_byte;
            S_PAY: begin
                out_valid = hold_v;
                out_data  = hold_data;
            end
            S_CRC:  out_data  = crc;
            S_EOF:  out_data  = FRM_EOF_BYTE;
            default: out_valid = 1'b0;
        endcase
    end

    assign fire       = out_valid && out_ready;
    assign busy       = (s_q.st != S_IDLE);
    assign fetch_want = (s_q.st == S_PAY);
    assign pay_take   = (s_q.st == S_PAY) && fire;
    assign crc_clr    = (s_q.st == S_IDLE) && start;
    assign crc_en     = fire && (s_q.st == S_TYPE || s_q.st == S_LEN ||
                                 s_q.st == S_ADDR || s_q.st == S_PAY);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: if (start) begin
                s_d.st   = S_SOF;
                s_d.typ  = hdr_type;
                s_d.len  = hdr_len;
                s_d.addr = hdr_addr;
                s_d.cnt  = '0;
            end
            S_SOF:  if (fire) s_d.st = S_TYPE;
            S_TYPE: if (fire) s_d.st = S_LEN;
            S_LEN:  if (fire) begin
                s_d.st  = S_ADDR;
                s_d.cnt = DW'(ADDR_BYTES - 1);
            end
            S_ADDR: if (fire) begin
                if (s_q.cnt == '0) s_d.st = S_PAY;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            S_PAY:  if (fire) begin
                if (s_q.cnt == s_q.len) s_d.st = S_CRC;
                else                    s_d.cnt = s_q.cnt + 1'b1;
            end
            S_CRC:  if (fire) s_d.st = S_EOF;
            S_EOF:  if (fire) s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, default: '0};
        else        s_q <= s_d;
    end

    // R6
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fire));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);
    // R7
    hdr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (s_q.typ == $past(s_q.typ) &&
                             s_q.addr == $past(s_q.addr) &&
                             s_q.len == $past(s_q.len)));
    // R3
    pay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_PAY) |-> (s_q.cnt <= s_q.len));
    // R5
    eof_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_EOF && fire) |=> !busy);

endmodule

// File: rtl/frm_pkt_tx.sv
module frm_pkt_tx #(
    parameter int         DW         = 8,
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] CRC_POLY   = 8'h07,
    parameter logic [7:0] CRC_INIT   = 8'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DW-1:0]            hdr_type,
    input  logic [DW-1:0]            hdr_len,
    input  logic [DW*ADDR_BYTES-1:0] hdr_addr,
    output logic                     busy,
    output logic                     pl_req,
    input  logic [DW-1:0]            pl_data,
    output logic [DW-1:0]            out_data,
    output logic                     out_valid,
    input  logic                     out_ready
);
    logic          fetch_want, pay_take, crc_clr, crc_en, hold_v;
    logic [DW-1:0] hold_data, crc;

    frm_seq #(.DW(DW), .ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hdr_type(hdr_type), .hdr_len(hdr_len), .hdr_addr(hdr_addr),
        .out_ready(out_ready), .hold_v(hold_v), .hold_data(hold_data),
        .crc(crc), .out_valid(out_valid), .out_data(out_data),
        .busy(busy), .fetch_want(fetch_want), .pay_take(pay_take),
        .crc_clr(crc_clr), .crc_en(crc_en)
    );

    frm_fetch #(.DW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .want(fetch_want), .take(pay_take),
        .pl_data(pl_data), .pl_req(pl_req),
        .hold_v(hold_v), .hold_data(hold_data)
    );

    frm_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(out_data), .crc(crc)
    );

    // R9
    req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_req |-> busy);

endmodule

// File: tb/sim_frm_pkt_tx.sv
`timescale 1ns/1ps
module sim_frm_pkt_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  hdr_type = '0, hdr_len = '0;
    logic [23:0] hdr_addr = '0;
    logic        busy, pl_req, out_valid;
    logic [7:0]  pl_data = '0, out_data;
    logic        out_ready = 1'b0;

    int n_run = 0, n_fail = 0;
    int ready_mode = 0;
    int cyc = 0;
    int inject_at = -1;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] pay_q[$];
    int         req_cnt = 0;

    bit         model_busy = 1'b0;
    bit         prev_v = 1'b0, prev_r = 1'b0, prev_req = 1'b0;
    logic [7:0] prev_d = '0;

    always #10 clk = ~clk;

    frm_pkt_tx u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hdr_type(hdr_type), .hdr_len(hdr_len), .hdr_addr(hdr_addr),
        .busy(busy), .pl_req(pl_req), .pl_data(pl_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        repeat (8) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    // monitor and reference model, compared on every clock
    always begin
        bit next_busy;
        @(negedge clk);
        cyc++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'($urandom % 2);
            default: out_ready = (cyc % 4 == 3);
        endcase
        #5;
        if (rst_n) begin
            next_busy = model_busy;
            // R8 busy tracks the model
            chk(busy == model_busy, "R8", "busy", busy, model_busy);
            // R8 no byte offered while idle
            if (!model_busy) chk(!out_valid, "R8", "valid while idle", out_valid, 0);
            // R6 stalled byte held
            if (prev_v && !prev_r)
                chk(out_valid && out_data == prev_d, "R6", "stalled byte",
                    out_data, prev_d);
            // R7 start accepted only when idle
            if (start && !model_busy) next_busy = 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected byte", out_data, 0);
                end else begin
                    chk(out_data == exp_q[0], tag_q[0], "byte", out_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                    if (exp_q.size() == 0) next_busy = 1'b0;
                end
            end
            // R9 request protocol
            if (pl_req) begin
                chk(!prev_req, "R9", "back-to-back request", 1, 0);
                if (pay_q.size() == 0) chk(1'b0, "R9", "excess request", req_cnt, 0);
                else pl_data = pay_q.pop_front();
                req_cnt++;
            end
            prev_v = out_valid; prev_r = out_ready; prev_d = out_data;
            prev_req = pl_req;
            model_busy = next_busy;
        end
    end

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    // called at a negedge; starts the frame in this cycle
    task automatic send(input logic [7:0] ty, input int count, input logic [23:0] ad,
                        input logic [7:0] seed);
        logic [7:0] c, ln, p;
        int k;
        ln = 8'(count - 1);
        c = 8'h00;
        push(8'h3C, "R1");
        push(ty, "R2"); c = ref_crc(c, ty);
        push(ln, "R3"); c = ref_crc(c, ln);
        push(ad[23:16], "R2"); c = ref_crc(c, ad[23:16]);
        push(ad[15:8],  "R2"); c = ref_crc(c, ad[15:8]);
        push(ad[7:0],   "R2"); c = ref_crc(c, ad[7:0]);
        for (int i = 0; i < count; i++) begin
            p = 8'(seed + i * 37);
            pay_q.push_back(p);
            push(p, "R3");
            c = ref_crc(c, p);
        end
        push(c, "R4");
        push(8'hA5, "R5");
        req_cnt = 0;
        hdr_type = ty; hdr_len = ln; hdr_addr = ad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (exp_q.size() != 0) begin
            if (k == inject_at) begin
                start = 1'b1; hdr_type = ~ty; hdr_len = 8'h02; hdr_addr = ~ad;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        // R9 one request per payload byte
        chk(req_cnt == count, "R9", "request count", req_cnt, count);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #5;
        // R10 reset state
        chk(!busy, "R10", "busy in reset", busy, 0);
        chk(!out_valid, "R10", "valid in reset", out_valid, 0);
        chk(!pl_req, "R10", "req in reset", pl_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        ready_mode = 0;
        send(8'h11, 1, 24'h123456, 8'h5A);      // R3 minimum payload
        send(8'h22, 4, 24'hABCDEF, 8'h01);      // R7 back-to-back start
        ready_mode = 2;
        send(8'h7E, 5, 24'h00FF00, 8'hC3);      // R6 periodic stall
        ready_mode = 1;
        inject_at = 6;
        send(8'h33, 3, 24'h0A0B0C, 8'h90);      // R7 start during header
        inject_at = 20;
        send(8'h44, 6, 24'hFEDCBA, 8'h10);      // R7 start during payload
        inject_at = -1;
        send(8'h99, 256, 24'h800001, 8'hE7);    // R3 maximum payload
        ready_mode = 0;
        send(8'h00, 2, 24'h000000, 8'h00);      // R4 zero header
        repeat (6) @(negedge clk);
        // R7 no frame was queued by the ignored starts
        chk(!busy && exp_q.size() == 0, "R7", "idle at end", busy, 0);
        chk(pay_q.size() == 0, "R9", "payload left over", pay_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule